// File: doc/BRIEF.md
# Gated serial clock generator

This block derives the clock for an external serial flash from the internal clock. Software chooses a divide ratio of 1, 2, 4 or 8 and a quarter-period phase shift for the output. Two enable bits both have to be set for the clock to run.

The block reports two conditions on status outputs. One says the generated clock has really halted. The other says the serial engine, which is outside this block, has no transfer in progress.

Reconfiguration follows a fixed handshake:
1. Software drops an enable.
2. Software polls until the halted flag is set.
3. Software changes the ratio or phase.
4. Software sets the enables again.
5. Software polls until the halted flag clears.

The generator guarantees that a halt never cuts a high pulse short. It also guarantees that a new ratio never takes hold in the middle of a period.

Top module: `sclk_gen`

## Requirements
- R1: With `div_sel_i` = 0, 1, 2 or 3 the output period is 1, 2, 4 or 8 internal cycles. The ratio is N = 2^`div_sel_i`. For N ≥ 2 with `phase90_i` = 0, take the first rising internal edge that sees both enables set as sample 0. On sample k the output is high when (k mod N) < N/2, and low otherwise.
- R2: The generator starts only when `int_clk_en_i` and `boot_clk_en_i` are both 1. With either one at 0, a halted generator stays halted, the output stays low and `clk_stopped_o` stays 1.
- R3: With `phase90_i` = 1 and N ≥ 4, the high window is delayed by N/4 internal cycles. The output is then high on sample k when ((k mod N) + N − N/4) mod N < N/2. For N = 1 and N = 2, `phase90_i` has no effect on the output.
- R4: After an enable drops, the output keeps following its pattern until the current period completes. It then halts low at the period boundary, without any shortened high pulse.
- R5: `clk_stopped_o` rises one cycle after the generator halts. It falls one cycle after the generator restarts, so it still reads 1 on sample 0 of a restart and reads 0 from sample 1 onward.
- R6: Changes to `div_sel_i` or `phase90_i` while the generator runs have no effect on the running output. These inputs are captured only while the generator is halted, and the captured values apply from the next restart.
- R7: For N = 1 the output is the internal clock passed through a glitch-free clock gate. It is low on sample 0 and high on every later sample while running. After an enable drop it gives exactly one more high pulse and then stays low.
- R8: `engine_idle_o` equals the inverse of `engine_busy_i` as it was one cycle earlier.
- R9: After reset the output is low, `clk_stopped_o` = 1, `engine_idle_o` = 1 and the captured ratio is ÷1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| int_clk_en_i | input | 1 | Internal clock enable |
| boot_clk_en_i | input | 1 | Second clock enable, needed together with the first |
| div_sel_i | input | 2 | Divide select: ratio 2^value |
| phase90_i | input | 1 | 0: 180-degree clock, 1: high window delayed a quarter period |
| engine_busy_i | input | 1 | Serial engine has a transfer in progress |
| sclk_o | output | 1 | Gated, divided serial clock |
| clk_stopped_o | output | 1 | Generator is halted |
| engine_idle_o | output | 1 | Registered idle indication of the serial engine |

## Verification
The assertions check four things on every cycle:
- A halt only follows a low output cycle.
- The halted flag tracks the run state with one cycle of delay in both directions.
- The captured ratio and phase cannot move while running.
- A halted generator never starts without both enables, and the idle flag follows the busy input.

Only the bench's scenarios can show the actual output waveforms for each ratio and phase. The same holds for the exact sample where a mid-period halt takes effect, the single extra pulse of the gated ÷1 path, and that a ratio written during a run appears only after the next restart.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

  // Width of the divide select field; ratio is 2**select.
  localparam int SEL_W = 2;
  // Counter wide enough for the largest ratio.
  localparam int CNT_W = (1 << SEL_W) - 1;

  typedef logic [SEL_W-1:0] ratio_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // Final count value of one output period for a given select.
  function automatic cnt_t period_last(input ratio_t r);
    return cnt_t'((1 << r) - 1);
  endfunction

  // Output level at count c of a period, for ratio 2**r and phase choice.
  function automatic logic level_at(input cnt_t c, input ratio_t r, input logic ph90);
    int n;
    int q;
    int pos;
    n   = 1 << r;
    q   = ph90 ? (n >> 2) : 0;
    pos = (int'(c) + n - q) % n;
    return (pos < (n >> 1));
  endfunction

endpackage

// File: rtl/sclk_gen_ratio_reg.sv
module sclk_gen_ratio_reg
  import sclk_gen_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  ratio_t sel_i,
  input  logic   ph90_i,
  output ratio_t ratio_eff_o,
  output logic   ph90_eff_o,
  output ratio_t ratio_q_o,
  output logic   ph90_q_o
);

  ratio_t ratio_q;
  logic   ph90_q;

  // While halted the software value passes straight through so that a
  // restart edge already uses it; while running the captured copy rules.
  assign ratio_eff_o = run_i ? ratio_q : sel_i;
  assign ph90_eff_o  = run_i ? ph90_q  : ph90_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= '0;
      ph90_q  <= 1'b0;
    end else if (!run_i) begin
      ratio_q <= sel_i;
      ph90_q  <= ph90_i;
    end
  end

  assign ratio_q_o = ratio_q;
  assign ph90_q_o  = ph90_q;

endmodule

// File: rtl/sclk_gen_divider.sv
module sclk_gen_divider
  import sclk_gen_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  ratio_t ratio_i,
  input  logic   ph90_i,
  output logic   run_o,
  output logic   sclk_o
);

  cnt_t cnt_q, cnt_d;
  logic run_q, run_d;
  logic sclk_q, sclk_d;
  logic at_last;

  assign at_last = (cnt_q == period_last(ratio_i));

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!run_q) begin
      if (en_i) begin
        run_d = 1'b1;
        cnt_d = '0;
      end
    end else if (at_last) begin
      // Period boundary: the only place a halt may happen.
      cnt_d = '0;
      run_d = en_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    sclk_d = run_d & level_at(cnt_d, ratio_i, ph90_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign run_o  = run_q;
  assign sclk_o = sclk_q;

endmodule

// File: rtl/sclk_gen_icg.sv
module sclk_gen_icg (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);

  logic en_lat;

  // Enable is only allowed to change while the clock is low.
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign gclk_o = clk_i & en_lat;

endmodule

// File: rtl/sclk_gen_status.sv
module sclk_gen_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic busy_i,
  output logic stopped_o,
  output logic idle_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stopped_o <= 1'b1;
      idle_o    <= 1'b1;
    end else begin
      stopped_o <= ~run_i;
      idle_o    <= ~busy_i;
    end
  end

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_gen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               int_clk_en_i,
  input  logic               boot_clk_en_i,
  input  logic [SEL_W-1:0]   div_sel_i,
  input  logic               phase90_i,
  input  logic               engine_busy_i,
  output logic               sclk_o,
  output logic               clk_stopped_o,
  output logic               engine_idle_o
);

  // Named internal events, also observed by the bound checker.
  logic   en_w;
  logic   run_w;
  logic   div_clk_w;
  logic   gclk_w;
  logic   div1_w;
  ratio_t ratio_eff_w;
  ratio_t ratio_q_w;
  logic   ph_eff_w;
  logic   ph_q_w;

  assign en_w   = int_clk_en_i & boot_clk_en_i;
  assign div1_w = (ratio_q_w == '0);

  sclk_gen_ratio_reg u_ratio (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_w),
    .sel_i       (div_sel_i),
    .ph90_i      (phase90_i),
    .ratio_eff_o (ratio_eff_w),
    .ph90_eff_o  (ph_eff_w),
    .ratio_q_o   (ratio_q_w),
    .ph90_q_o    (ph_q_w)
  );

  sclk_gen_divider u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_w),
    .ratio_i (ratio_eff_w),
    .ph90_i  (ph_eff_w),
    .run_o   (run_w),
    .sclk_o  (div_clk_w)
  );

  sclk_gen_icg u_icg (
    .clk_i  (clk_i),
    .en_i   (run_w & div1_w),
    .gclk_o (gclk_w)
  );

  sclk_gen_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_w),
    .busy_i    (engine_busy_i),
    .stopped_o (clk_stopped_o),
    .idle_o    (engine_idle_o)
  );

  // Select only changes while halted, when both paths are low.
  assign sclk_o = div1_w ? gclk_w : div_clk_w;

endmodule

// File: rtl/sclk_gen_checker.sv
module sclk_gen_checker
  import sclk_gen_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   int_clk_en_i,
  input logic   boot_clk_en_i,
  input logic   engine_busy_i,
  input logic   clk_stopped_o,
  input logic   engine_idle_o,
  input logic   run_w,
  input logic   div_clk_w,
  input ratio_t ratio_q_w,
  input logic   ph_q_w
);

  assert_halt_after_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_w) |-> !$past(div_clk_w));

  assert_flag_on_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_w) |=> clk_stopped_o);

  assert_flag_off_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_w) |=> !clk_stopped_o);

  assert_hold_setting_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && $past(run_w)) |-> ($stable(ratio_q_w) && $stable(ph_q_w)));

  assert_both_enables_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_w && !(int_clk_en_i && boot_clk_en_i)) |=> !run_w);

  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engine_busy_i |=> !engine_idle_o);

  assert_idle_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !engine_busy_i |=> engine_idle_o);

endmodule

bind sclk_gen sclk_gen_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .int_clk_en_i  (int_clk_en_i),
  .boot_clk_en_i (boot_clk_en_i),
  .engine_busy_i (engine_busy_i),
  .clk_stopped_o (clk_stopped_o),
  .engine_idle_o (engine_idle_o),
  .run_w         (run_w),
  .div_clk_w     (div_clk_w),
  .ratio_q_w     (ratio_q_w),
  .ph_q_w        (ph_q_w)
);

// File: tb/sclk_gen_tb.sv
`timescale 1ns/1ps
module sclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       int_en = 1'b0;
  logic       boot_en = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       ph90 = 1'b0;
  logic       busy = 1'b0;
  logic       sclk;
  logic       stopped;
  logic       idle;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic  sclk;
    logic  stopped;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // Bench's own view of the active ratio and phase.
  int act_n  = 1;
  bit act_ph = 1'b0;
  int idx    = 0;

  always #2.5 clk = ~clk;

  sclk_gen u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .int_clk_en_i  (int_en),
    .boot_clk_en_i (boot_en),
    .div_sel_i     (div_sel),
    .phase90_i     (ph90),
    .engine_busy_i (busy),
    .sclk_o        (sclk),
    .clk_stopped_o (stopped),
    .engine_idle_o (idle)
  );

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected level on sample k of a running clock with N >= 2.
  function automatic bit want_high(input int k, input int n, input bit ph);
    int shift;
    int slot;
    shift = ph ? n / 4 : 0;
    slot  = (k % n) - shift;
    if (slot < 0) slot = slot + n;
    return slot < n / 2;
  endfunction

  function automatic bit run_level(input int k, input int n, input bit ph);
    if (n == 1) return (k != 0);
    return want_high(k, n, ph);
  endfunction

  task automatic push(input logic s, input logic st, input string tag);
    exp_t e;
    e.sclk = s;
    e.stopped = st;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: one expected item per sample point, mid high phase.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check_bit(e.tag, "sclk", sclk, e.sclk);
        check_bit(e.tag, "stopped", stopped, e.stopped);
      end
    end
  end

  task automatic start_run(input int sel, input bit ph, input int m, input string tag);
    @(negedge clk);
    int_en  = 1'b1;
    boot_en = 1'b1;
    div_sel = 2'(sel);
    ph90    = ph;
    act_n   = 1 << sel;
    act_ph  = ph;
    for (int k = 0; k < m; k++) push(run_level(k, act_n, act_ph), k == 0, tag);
    idx = m - 1;
    repeat (m) @(negedge clk);
  endtask

  // Called at a negedge while running: move the select inputs, expect no change.
  task automatic hold_run(input int new_sel, input bit new_ph, input int m);
    div_sel = 2'(new_sel);
    ph90    = new_ph;
    for (int k = idx + 1; k <= idx + m; k++) push(run_level(k, act_n, act_ph), 1'b0, "R6");
    idx = idx + m;
    repeat (m) @(negedge clk);
  endtask

  task automatic stop_run(input string tag);
    int j;
    int cnt;
    int_en = 1'b0;
    j = idx + 1;
    while ((j % act_n) != 0) j++;
    cnt = 0;
    for (int k = idx + 1; k < j; k++) begin
      push(run_level(k, act_n, act_ph), 1'b0, tag);
      cnt++;
    end
    push(act_n == 1, 1'b0, tag);   // halt edge; one final pulse for ratio 1 (R7)
    push(1'b0, 1'b1, "R5");
    push(1'b0, 1'b1, tag);
    cnt = cnt + 3;
    repeat (cnt) @(negedge clk);
  endtask

  task automatic one_enable(input logic a, input logic b, input int m);
    @(negedge clk);
    int_en  = a;
    boot_en = b;
    for (int k = 0; k < m; k++) push(1'b0, 1'b1, "R2");
    repeat (m) @(negedge clk);
    int_en  = 1'b0;
    boot_en = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    check_bit("R9", "sclk", sclk, 1'b0);
    check_bit("R9", "stopped", stopped, 1'b1);
    check_bit("R9", "idle", idle, 1'b1);

    // R1: ratio 2, plain phase
    start_run(1, 1'b0, 6, "R1");
    stop_run("R4");

    // R6: ratio 4 running, select moved to 8 and phase flipped mid-run
    start_run(2, 1'b0, 6, "R1");
    hold_run(3, 1'b1, 6);
    stop_run("R4");
    // restart: the captured ratio 8 / 90 degrees applies now; mid-period stop
    start_run(3, 1'b1, 11, "R6");
    stop_run("R4");

    // R3: ratio 4, quarter shift
    start_run(2, 1'b1, 6, "R3");
    stop_run("R4");

    // R7: ratio 1 gated path
    start_run(0, 1'b0, 5, "R7");
    stop_run("R7");
    // R3: phase has no effect at ratio 1 and 2
    start_run(0, 1'b1, 4, "R3");
    stop_run("R7");
    start_run(1, 1'b1, 5, "R3");
    stop_run("R4");

    // R2: one enable alone does nothing
    one_enable(1'b1, 1'b0, 5);
    one_enable(1'b0, 1'b1, 5);

    // R8: idle follows busy one cycle later
    @(negedge clk);
    busy = 1'b1;
    @(posedge clk);
    #1;
    check_bit("R8", "idle", idle, 1'b0);
    @(negedge clk);
    busy = 1'b0;
    @(posedge clk);
    #1;
    check_bit("R8", "idle", idle, 1'b1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule